// File: doc/BRIEF.md
# I/O Chip-Select and Strobe Controller

This block sits between a processor's local bus and a group of slow peripherals. When the processor opens a bus cycle with an address strobe, the block compares the address with one window per device and captures a chip select for the winning device. At the same edge it captures a data-buffer enable and the transfer direction. These flags are synchronous set-and-hold registers. They stay set until the edge on which the processor marks the final transfer and the block reports ready in the same cycle.

While a select is held, a phase machine times the access in whole clock cycles. It waits out an address-to-strobe setup time and then drives the read or write strobe for a fixed width. Next it returns a one-cycle ready pulse with the strobe already released. Last it enforces a recovery gap before any further strobe may start. The cycle counts are parameters. The defaults (setup 1, strobe 2, recovery 3) are sized for the fastest supported bus clock, so the minimum times still hold at slower clocks. A new address strobe that arrives during the recovery gap registers its select at once, but its strobe waits until the gap has ended.

Top module: `io_strobe_ctrl`

## Requirements
- R1: A chip select sets on a rising edge where `ads_i` is 1, the address lies inside that device's inclusive window [DEV_LO, DEV_HI], and no select is already held. If `ads_i` is 0, if no window matches, or if a select is already held, the selects do not change. Device d uses bits [d*ADDR_W +: ADDR_W] of DEV_LO and DEV_HI. Bit d of `cs_o` is device d.
- R2: Where windows overlap, the lowest device index wins. At most one bit of `cs_o` is ever 1.
- R3: A held select, `buf_en_o` and the captured direction stay constant until an edge where `ready_o` and `last_i` are both 1. That edge clears the select and `buf_en_o`. `buf_en_o` is 1 exactly while a select is held.
- R4: The phase machine stays idle with no strobe while no select is held. In the cycle after a select appears, a setup phase of SETUP_CYC cycles begins, and no strobe is driven during it.
- R5: After setup, exactly one strobe is driven for STROBE_CYC cycles. `rd_strobe_o` is driven if `wr_i` was 0 when the select was captured, and `wr_strobe_o` if it was 1. Changes on `wr_i` after capture have no effect.
- R6: `ready_o` is 1 for exactly one cycle, directly after the strobe phase, and no strobe is driven in that cycle.
- R7: After ready come RECOV_CYC recovery cycles with no strobe and no ready, and then one idle cycle. If `last_i` was 0 at ready, the select is kept, and after the idle cycle a new setup/strobe/ready sequence runs for the same device.
- R8: An address strobe that arrives during recovery, after the previous select has cleared, sets its select on that edge. Its setup phase starts only in the cycle after the idle cycle that ends recovery.
- R9: A synchronous active-low reset clears all selects, `buf_en_o`, both strobes and `ready_o`, and returns the machine to idle on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_i | input | 1 | Address strobe: marks the start of a bus cycle |
| addr_i | input | ADDR_W | Bus address |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| last_i | input | 1 | Final transfer of the current bus cycle |
| cs_o | output | N_DEV | Chip select for each device, one-hot or zero |
| buf_en_o | output | 1 | Data-buffer enable, held together with the select |
| rd_strobe_o | output | 1 | Read strobe to the peripherals |
| wr_strobe_o | output | 1 | Write strobe to the peripherals |
| ready_o | output | 1 | One-cycle ready back to the processor |

## Verification
Each access is timed from the edge that samples the address strobe. The select and buffer enable show one cycle after that edge (call this offset 0). Setup occupies offsets 1 to SETUP_CYC. The strobe follows for STROBE_CYC cycles. Ready comes at offset SETUP_CYC+STROBE_CYC+1, recovery follows for RECOV_CYC cycles, and the machine is idle at offset SETUP_CYC+STROBE_CYC+RECOV_CYC+2. The bench drives inputs on the falling edge and compares the complete output vector on every falling edge against this offset table. It does this for reads, writes, bursts, an address strobe injected mid-access and one injected during recovery, so a single-cycle shift at any stage is reported.

// File: rtl/io_strobe_pkg.sv
// Package: shared types and helpers for the I/O strobe controller.
// Holds the phase encoding of the timing machine and a small helper
// that sizes the cycle counter.
package io_strobe_pkg;

    // Phases of one peripheral access.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_READY   = 3'd3,
        PH_RECOVER = 3'd4
    } io_phase_e;

    // Largest of three cycle counts; used to size the phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/io_range_decode.sv
// Module: io_range_decode
// Compares the bus address with one inclusive window per device and
// returns a one-hot (or empty) hit vector. Overlapping windows are
// resolved by fixed priority: the lowest device index wins.
// Assumes DEV_LO[d] <= DEV_HI[d] for every device d.
module io_range_decode #(
    parameter int                      N_DEV  = 4,
    parameter int                      ADDR_W = 16,
    parameter logic [N_DEV*ADDR_W-1:0] DEV_LO = '0,
    parameter logic [N_DEV*ADDR_W-1:0] DEV_HI = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_DEV-1:0]  hit
);

    logic [N_DEV-1:0] raw_hit;

    // One window comparator per device.
    for (genvar d = 0; d < N_DEV; d++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = DEV_LO[d*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = DEV_HI[d*ADDR_W +: ADDR_W];
        assign raw_hit[d] = (addr >= LO) && (addr <= HI);
    end

    // Keep only the lowest-index hit: isolate the least significant set bit.
    always_comb begin
        hit = raw_hit & (~raw_hit + N_DEV'(1));
    end

endmodule

// File: rtl/io_select_hold.sv
// Module: io_select_hold
// Set-and-hold registers for the device selects, the data-buffer enable
// and the captured transfer direction. A capture happens on an address
// strobe with a decode hit while nothing is held. Everything is released
// on the edge where the access is marked complete (ready with last).
// Assumes hit is one-hot or zero.
module io_select_hold #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads,
    input  logic [N_DEV-1:0] hit,
    input  logic             wr,
    input  logic             done,
    output logic [N_DEV-1:0] sel,
    output logic             buf_en,
    output logic             dir_wr
);

    logic held;
    logic take;

    // Capture only when idle-of-select and a matching strobe arrives.
    always_comb begin
        held = |sel;
        take = ads && (|hit) && !held;
    end

    // One set/hold flag per device.
    for (genvar d = 0; d < N_DEV; d++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                 sel[d] <= 1'b0;
            else if (done)              sel[d] <= 1'b0;
            else if (take && hit[d])    sel[d] <= 1'b1;
        end
    end

    // Data-buffer enable: set and cleared with the selects.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_en <= 1'b0;
        else if (done)   buf_en <= 1'b0;
        else if (take)   buf_en <= 1'b1;
    end

    // Direction is frozen at capture time.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_wr <= 1'b0;
        else if (take)   dir_wr <= wr;
    end

endmodule

// File: rtl/io_phase_fsm.sv
// Module: io_phase_fsm
// Times one peripheral access: setup, strobe, one ready cycle, recovery,
// then idle. Starts from idle whenever a select is held. Strobes and
// ready are registered from the next phase, so they are glitch-free.
// Assumes SETUP_CYC, STROBE_CYC and RECOV_CYC are all at least 1.
module io_phase_fsm
    import io_strobe_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int RECOV_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic dir_wr,
    output logic rd_strobe,
    output logic wr_strobe,
    output logic ready
);

    localparam int CNT_MAX = max3(SETUP_CYC, STROBE_CYC, RECOV_CYC);
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    io_phase_e        phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    // Next phase and counter reload.
    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        cnt_zero = (cnt_q == '0);
        unique case (phase_q)
            PH_IDLE: begin
                if (go) begin
                    phase_d = PH_SETUP;
                    cnt_d   = CNT_W'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    phase_d = PH_STROBE;
                    cnt_d   = CNT_W'(STROBE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_zero) phase_d = PH_READY;
                else          cnt_d   = cnt_q - 1'b1;
            end
            PH_READY: begin
                phase_d = PH_RECOVER;
                cnt_d   = CNT_W'(RECOV_CYC - 1);
            end
            PH_RECOVER: begin
                if (cnt_zero) phase_d = PH_IDLE;
                else          cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered strobe and ready outputs, decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_strobe <= 1'b0;
            wr_strobe <= 1'b0;
            ready     <= 1'b0;
        end else begin
            rd_strobe <= (phase_d == PH_STROBE) && !dir_wr;
            wr_strobe <= (phase_d == PH_STROBE) &&  dir_wr;
            ready     <= (phase_d == PH_READY);
        end
    end

endmodule

// File: rtl/io_strobe_ctrl.sv
// Module: io_strobe_ctrl (top)
// Chip-select and strobe controller for slow bus peripherals. Decodes
// the address on an address strobe, holds the winning select plus the
// buffer enable until ready coincides with last-transfer, and times the
// strobe, ready and recovery phases in clock cycles.
// Assumes the processor holds last_i valid in the ready cycle.
module io_strobe_ctrl #(
    parameter int                      N_DEV      = 4,
    parameter int                      ADDR_W     = 16,
    parameter logic [N_DEV*ADDR_W-1:0] DEV_LO     = {16'h4000, 16'h2800, 16'h2000, 16'h1000},
    parameter logic [N_DEV*ADDR_W-1:0] DEV_HI     = {16'h40FF, 16'h3FFF, 16'h2FFF, 16'h1FFF},
    parameter int                      SETUP_CYC  = 1,
    parameter int                      STROBE_CYC = 2,
    parameter int                      RECOV_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              last_i,
    output logic [N_DEV-1:0]  cs_o,
    output logic              buf_en_o,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic              ready_o
);

    logic [N_DEV-1:0] hit;
    logic             done;
    logic             dir_wr;
    logic             go;

    // Access completes when ready meets last-transfer.
    always_comb begin
        done = ready_o && last_i;
        go   = |cs_o;
    end

    io_range_decode #(
        .N_DEV  (N_DEV),
        .ADDR_W (ADDR_W),
        .DEV_LO (DEV_LO),
        .DEV_HI (DEV_HI)
    ) u_decode (
        .addr (addr_i),
        .hit  (hit)
    );

    io_select_hold #(
        .N_DEV (N_DEV)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ads    (ads_i),
        .hit    (hit),
        .wr     (wr_i),
        .done   (done),
        .sel    (cs_o),
        .buf_en (buf_en_o),
        .dir_wr (dir_wr)
    );

    io_phase_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .RECOV_CYC  (RECOV_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .dir_wr    (dir_wr),
        .rd_strobe (rd_strobe_o),
        .wr_strobe (wr_strobe_o),
        .ready     (ready_o)
    );

endmodule

// File: rtl/io_strobe_ctrl_chk.sv
// Module: io_strobe_ctrl_chk
// Property checker for io_strobe_ctrl, attached by bind below.
// Observes ports only, plus a strobe-length counter of its own.
module io_strobe_ctrl_chk #(
    parameter int N_DEV      = 4,
    parameter int STROBE_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             last_i,
    input logic [N_DEV-1:0] cs_o,
    input logic             buf_en_o,
    input logic             rd_strobe_o,
    input logic             wr_strobe_o,
    input logic             ready_o
);

    int unsigned strobe_run;

    // Counts consecutive strobe cycles; cleared after a non-strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                         strobe_run <= 0;
        else if (rd_strobe_o || wr_strobe_o) strobe_run <= strobe_run + 1;
        else                                 strobe_run <= 0;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o)); // R2
    AST_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cs_o) && !(ready_o && last_i)) |=> $stable(cs_o)); // R3
    AST_SELECT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cs_o) && ready_o && last_i) |=> (cs_o == '0)); // R3
    AST_BUF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en_o == (|cs_o)); // R3
    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_o || wr_strobe_o) |-> (|cs_o)); // R4
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o)); // R5
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (strobe_run == STROBE_CYC)); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o); // R6
    AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !(rd_strobe_o || wr_strobe_o)); // R6
    AST_RECOVERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !(rd_strobe_o || wr_strobe_o)); // R7

endmodule

bind io_strobe_ctrl io_strobe_ctrl_chk #(
    .N_DEV      (N_DEV),
    .STROBE_CYC (STROBE_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_i      (last_i),
    .cs_o        (cs_o),
    .buf_en_o    (buf_en_o),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .ready_o     (ready_o)
);

// File: tb/io_strobe_ctrl_tb_top.sv
// Directed bench for io_strobe_ctrl: one task per scenario. Inputs are
// driven and outputs sampled on the falling clock edge.
module io_strobe_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P_SETUP    = 1;
    localparam int P_STROBE   = 2;
    localparam int P_RECOV    = 3;
    localparam int J_READY    = P_SETUP + P_STROBE + 1;
    localparam int J_LAST     = P_SETUP + P_STROBE + P_RECOV + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        blast = 1'b0;
    logic [3:0]  cs;
    logic        buf_en, rd_s, wr_s, rdy;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    io_strobe_ctrl #(
        .N_DEV      (4),
        .ADDR_W     (16),
        .DEV_LO     ({16'h4000, 16'h2800, 16'h2000, 16'h1000}),
        .DEV_HI     ({16'h40FF, 16'h3FFF, 16'h2FFF, 16'h1FFF}),
        .SETUP_CYC  (P_SETUP),
        .STROBE_CYC (P_STROBE),
        .RECOV_CYC  (P_RECOV)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ads_i       (ads),
        .addr_i      (addr),
        .wr_i        (wr),
        .last_i      (blast),
        .cs_o        (cs),
        .buf_en_o    (buf_en),
        .rd_strobe_o (rd_s),
        .wr_strobe_o (wr_s),
        .ready_o     (rdy)
    );

    // Compare and count one result.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Output vector {cs, buf_en, rd, wr, ready} expected at offset j.
    function automatic logic [7:0] expect_vec(input int j, input logic [3:0] c, input logic w);
        logic strb;
        strb = (j >= P_SETUP + 1) && (j <= P_SETUP + P_STROBE);
        return {c, |c, strb && !w, strb && w, j == J_READY};
    endfunction

    function automatic logic [7:0] out_vec();
        return {cs, buf_en, rd_s, wr_s, rdy};
    endfunction

    // Issue an address strobe; returns at offset 0 (select visible).
    task automatic start_access(input logic [15:0] a, input logic w);
        ads  = 1'b1;
        addr = a;
        wr   = w;
        @(negedge clk);
        ads  = 1'b0;
    endtask

    // Check one full access from offset 0 to J_LAST; optional injection
    // of an address strobe at offset inj_j (-1 for none).
    task automatic run_frame(input logic [3:0] exp_cs, input logic w, input logic last,
                             input int inj_j, input logic [15:0] inj_addr,
                             input logic inj_w, input logic [3:0] inj_cs, input string tag);
        blast = last;
        for (int j = 0; j <= J_LAST; j++) begin
            logic [3:0] c;
            c = ((j <= J_READY) || !last) ? exp_cs : 4'b0000;
            if (inj_j >= 0 && j > inj_j && c == 4'b0000) c = inj_cs;
            check($sformatf("%s offset %0d", tag, j), {24'h0, out_vec()}, {24'h0, expect_vec(j, c, w)});
            if (j == inj_j) begin
                ads  = 1'b1;
                addr = inj_addr;
                wr   = inj_w;
            end else begin
                ads  = 1'b0;
            end
            @(negedge clk);
        end
        ads = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check(tag, {24'h0, out_vec()}, 32'h0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 reset state", {24'h0, out_vec()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(2, "R4 idle after reset");
    endtask

    task automatic t_read_dev0();
        start_access(16'h1000, 1'b0);
        run_frame(4'b0001, 1'b0, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R1 R4 R5 R6 R7 read dev0");
        quiet(1, "R7 idle after read");
    endtask

    task automatic t_write_dev2();
        start_access(16'h3000, 1'b1);
        run_frame(4'b0100, 1'b1, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R5 write dev2");
        quiet(1, "R7 idle after write");
    endtask

    task automatic t_boundaries();
        start_access(16'h1FFF, 1'b0);
        run_frame(4'b0001, 1'b0, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R1 upper bound dev0");
        start_access(16'h40FF, 1'b1);
        run_frame(4'b1000, 1'b1, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R1 upper bound dev3");
        start_access(16'h4100, 1'b0);
        quiet(J_LAST, "R1 outside all windows");
        addr = 16'h2000;
        ads  = 1'b0;
        @(negedge clk);
        quiet(4, "R1 matching address without strobe");
    endtask

    task automatic t_priority();
        start_access(16'h2900, 1'b0);
        run_frame(4'b0010, 1'b0, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R2 overlap lowest wins");
    endtask

    task automatic t_busy_strobe();
        // Strobe at offset 1 while dev0 is held; also flips wr.
        start_access(16'h1234, 1'b0);
        run_frame(4'b0001, 1'b0, 1'b1, 1, 16'h4010, 1'b1, 4'b0000, "R1 R3 strobe while held ignored");
        quiet(1, "R3 no late select");
    endtask

    task automatic t_burst();
        start_access(16'h2004, 1'b1);
        run_frame(4'b0010, 1'b1, 1'b0, -1, 16'h0, 1'b0, 4'b0, "R3 R7 burst first beat");
        run_frame(4'b0010, 1'b1, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R7 burst second beat");
        quiet(1, "R7 idle after burst");
    endtask

    task automatic t_pending();
        start_access(16'h1800, 1'b0);
        run_frame(4'b0001, 1'b0, 1'b1, J_READY + 1, 16'h4004, 1'b1, 4'b1000, "R8 strobe during recovery");
        run_frame(4'b1000, 1'b1, 1'b1, -1, 16'h0, 1'b0, 4'b0, "R8 pending access");
        quiet(1, "R8 idle after pending");
    endtask

    task automatic t_reset_mid();
        start_access(16'h1000, 1'b0);
        for (int j = 0; j <= P_SETUP; j++) @(negedge clk);
        check("R5 strobe before reset", {31'h0, rd_s}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset during access", {24'h0, out_vec()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(J_LAST, "R9 quiet after reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_read_dev0();
        t_write_dev2();
        t_boundaries();
        t_priority();
        t_busy_strobe();
        t_burst();
        t_pending();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule